// File: doc/BRIEF.md
# Multi-Digit BCD Seven-Segment Decoder with Zero Suppression

This block turns a row of BCD digits into the segment drive lines of a seven-segment display, one set of seven lines per digit. The segments are active high, as a common-cathode display needs. Each digit stage has three control inputs: a lamp test that lights every segment, a blanking input that darkens the whole display, and a zero-suppression input. A stage whose suppression input is active and whose digit is zero goes dark. It then passes suppression on to the next lower digit, so leading zeros of a multi-digit number disappear.

The digit stages are chained inside the block, from the most significant digit down to the units digit. The suppression input of the top digit comes from a port. The suppression output of the units digit is brought out, so that another group of digits can continue the chain. When this output is high, the whole group shows nothing. The parameter `OUT_REG` selects a registered output with one clock of latency (the default) or a purely combinational path.

Top module: `bcd7_display_decoder`

## Requirements
- R1: Digit k occupies bits 4k+3..4k of `digit_code_i`, with bit 4k the least significant; digit 0 is the units digit. Codes 0 to 9 light these segments, written as g..a with a in the low bit: 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0000111, 8=1111111, 9=1101111.
- R2: Codes 10 to 15 turn off all seven segments of their digit, unless lamp test or blanking applies.
- R3: When `blank_i` is high, every segment of every digit is off, whatever the digit codes, the lamp test or the suppression input.
- R4: When `lamp_test_i` is high and `blank_i` is low, all seven segments of every digit are lit, including digits that zero suppression would otherwise blank.
- R5: A digit whose suppression input is high, whose code is 0 and which is not under lamp test shows no segments and drives its suppression output high. In every other case its suppression output is low.
- R6: The suppression input of the most significant digit is `zero_sup_i`. Each lower digit takes the suppression output of the digit just above it, so the first nonzero digit ends the chain and all digits below it show normally, zeros included.
- R7: `zero_sup_o` is the suppression output of the units digit. It is high only when every digit is zero, `zero_sup_i` is high and lamp test is low. `blank_i` does not change it.
- R8: Segment bit 7k+0 drives segment a of digit k, and bits 7k+1 to 7k+6 drive segments b to g in that order.
- R9: With `OUT_REG`=1, the outputs follow the inputs sampled at the previous rising clock edge. While `rst_ni` is low they clear to all zero at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| digit_code_i | input | 4*NUM_DIGITS | BCD codes, digit 0 (units) in the low nibble |
| lamp_test_i | input | 1 | Lights every segment when blanking is off |
| blank_i | input | 1 | Turns every segment off; highest priority |
| zero_sup_i | input | 1 | Suppression input of the most significant digit |
| seg_o | output | 7*NUM_DIGITS | Segment lines a..g per digit, active high |
| zero_sup_o | output | 1 | Suppression output of the units digit |

## Verification
The hardest state to reach is a long suppression chain, which ends at its lowest digit with `zero_sup_o` high. It needs every digit to be zero together with `zero_sup_i` high and lamp test low. Uniform random codes almost never produce it. The stimulus therefore draws each digit as zero with high probability and mixes these patterns with directed ones: the all-zero display, a nonzero digit in the middle followed by zeros, and lamp test or blanking applied on top of a fully suppressed row.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
    localparam int SEG_W  = 7;
    localparam int CODE_W = 4;
    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [CODE_W-1:0] code_t;
    localparam seg_t SEG_DARK = '0;
    localparam seg_t SEG_FULL = '1;
    localparam code_t CODE_ZERO = '0;
endpackage

// File: rtl/bcd7_glyph.sv
module bcd7_glyph
    import bcd7_pkg::*;
(
    input  code_t code_i,
    output seg_t  glyph_o
);
    // Segment vector packed as {g,f,e,d,c,b,a}.
    always_comb begin
        unique case (code_i)
            4'd0:    glyph_o = 7'b0111111;
            4'd1:    glyph_o = 7'b0000110;
            4'd2:    glyph_o = 7'b1011011;
            4'd3:    glyph_o = 7'b1001111;
            4'd4:    glyph_o = 7'b1100110;
            4'd5:    glyph_o = 7'b1101101;
            4'd6:    glyph_o = 7'b1111101;
            4'd7:    glyph_o = 7'b0000111;
            4'd8:    glyph_o = 7'b1111111;
            4'd9:    glyph_o = 7'b1101111;
            default: glyph_o = SEG_DARK;
        endcase
    end
endmodule

// File: rtl/bcd7_stage.sv
module bcd7_stage
    import bcd7_pkg::*;
(
    input  code_t code_i,
    input  logic  lamp_test_i,
    input  logic  blank_i,
    input  logic  sup_in_i,
    output seg_t  seg_o,
    output logic  sup_out_o
);
    seg_t glyph;
    logic is_zero;
    logic suppress;

    bcd7_glyph glyph_i (
        .code_i  (code_i),
        .glyph_o (glyph)
    );

    assign is_zero = (code_i == CODE_ZERO);
    // Lamp test wins over zero suppression and also breaks the chain.
    assign suppress = sup_in_i && is_zero && !lamp_test_i;

    always_comb begin
        if (blank_i) begin
            seg_o = SEG_DARK;
        end else if (lamp_test_i) begin
            seg_o = SEG_FULL;
        end else if (suppress) begin
            seg_o = SEG_DARK;
        end else begin
            seg_o = glyph;
        end
    end

    assign sup_out_o = suppress;
endmodule

// File: rtl/bcd7_display_decoder.sv
module bcd7_display_decoder
    import bcd7_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter bit OUT_REG    = 1'b1
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [CODE_W*NUM_DIGITS-1:0] digit_code_i,
    input  logic                      lamp_test_i,
    input  logic                      blank_i,
    input  logic                      zero_sup_i,
    output logic [SEG_W*NUM_DIGITS-1:0]  seg_o,
    output logic                      zero_sup_o
);
    localparam int SEGS_W = SEG_W * NUM_DIGITS;

    typedef struct packed {
        logic [SEGS_W-1:0] segs;
        logic              sup;
    } out_t;

    out_t out_d;
    out_t out_q;

    // chain[k+1] feeds digit k; chain[NUM_DIGITS] is the external input.
    logic [NUM_DIGITS:0] chain;
    logic [SEGS_W-1:0]   segs_comb;

    assign chain[NUM_DIGITS] = zero_sup_i;

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        seg_t stage_seg;
        bcd7_stage stage_i (
            .code_i      (digit_code_i[CODE_W*k +: CODE_W]),
            .lamp_test_i (lamp_test_i),
            .blank_i     (blank_i),
            .sup_in_i    (chain[k+1]),
            .seg_o       (stage_seg),
            .sup_out_o   (chain[k])
        );
        assign segs_comb[SEG_W*k +: SEG_W] = stage_seg;
    end

    always_comb begin
        out_d.segs = segs_comb;
        out_d.sup  = chain[0];
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign seg_o      = out_q.segs;
    assign zero_sup_o = out_q.sup;
endmodule

// File: rtl/bcd7_display_decoder_chk.sv
module bcd7_display_decoder_chk
    import bcd7_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter bit OUT_REG    = 1'b1
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic [CODE_W*NUM_DIGITS-1:0] digit_code_i,
    input logic                         lamp_test_i,
    input logic                         blank_i,
    input logic                         zero_sup_i,
    input logic [SEG_W*NUM_DIGITS-1:0]  seg_o,
    input logic                         zero_sup_o
);
    logic [CODE_W*NUM_DIGITS-1:0] code_p;
    logic lt_p, bl_p, zs_p, seen_q;

    always_ff @(posedge clk_i) begin
        seen_q <= rst_ni;
    end

    if (OUT_REG) begin : g_lat
        always_ff @(posedge clk_i) begin
            code_p <= digit_code_i;
            lt_p   <= lamp_test_i;
            bl_p   <= blank_i;
            zs_p   <= zero_sup_i;
        end

        a_r9_reset_clear: assert property (@(posedge clk_i)
            !rst_ni |=> (seg_o == '0 && !zero_sup_o));
    end else begin : g_nolat
        assign code_p = digit_code_i;
        assign lt_p   = lamp_test_i;
        assign bl_p   = blank_i;
        assign zs_p   = zero_sup_i;
    end

    a_r3_blank_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && bl_p) |-> (seg_o == '0));

    a_r4_lamp_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && lt_p && !bl_p) |-> (seg_o == '1));

    a_r7_chain_end_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && zero_sup_o) |-> (code_p == '0 && zs_p && !lt_p));

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
        a_r2_invalid_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (seen_q && !lt_p && code_p[CODE_W*k +: CODE_W] > 4'd9)
            |-> (seg_o[SEG_W*k +: SEG_W] == '0));
    end
endmodule

bind bcd7_display_decoder bcd7_display_decoder_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .OUT_REG    (OUT_REG)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .digit_code_i (digit_code_i),
    .lamp_test_i  (lamp_test_i),
    .blank_i      (blank_i),
    .zero_sup_i   (zero_sup_i),
    .seg_o        (seg_o),
    .zero_sup_o   (zero_sup_o)
);

// File: tb/bcd7_display_decoder_tb_top.sv
`timescale 1ns/1ps
module bcd7_display_decoder_tb_top;
    localparam int ND = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4*ND-1:0] codes = '0;
    logic            lt = 1'b0;
    logic            bl = 1'b0;
    logic            zs = 1'b0;
    logic [7*ND-1:0] segs;
    logic            zs_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd7_display_decoder #(.NUM_DIGITS(ND), .OUT_REG(1'b1)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .digit_code_i (codes),
        .lamp_test_i  (lt),
        .blank_i      (bl),
        .zero_sup_i   (zs),
        .seg_o        (segs),
        .zero_sup_o   (zs_out)
    );

    // Glyph table taken from R1; R2 for codes above 9.
    function automatic logic [6:0] ref_glyph(input logic [3:0] c);
        logic [6:0] t [10];
        t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return (c < 4'd10) ? t[c] : 7'h00;
    endfunction

    // Expected {zero_sup_o, seg_o} per R3 to R8.
    function automatic logic [7*ND:0] ref_out(input logic [4*ND-1:0] c,
                                              input logic l, input logic b, input logic z);
        logic [7*ND-1:0] s;
        logic sup;
        sup = z;
        s = '0;
        for (int k = ND - 1; k >= 0; k--) begin
            logic [3:0] d;
            logic dark;
            d = c[4*k +: 4];
            dark = sup && (d == 4'd0) && !l;
            if (b)           s[7*k +: 7] = 7'h00;
            else if (l)      s[7*k +: 7] = 7'h7F;
            else if (dark)   s[7*k +: 7] = 7'h00;
            else             s[7*k +: 7] = ref_glyph(d);
            sup = dark;
        end
        return {sup, s};
    endfunction

    task automatic apply_check(input logic [4*ND-1:0] c, input logic l, input logic b,
                               input logic z, input string req);
        logic [7*ND:0] exp;
        @(negedge clk);
        codes = c; lt = l; bl = b; zs = z;
        exp = ref_out(c, l, b, z);
        @(negedge clk);
        checks++;
        if ({zs_out, segs} !== exp) begin
            errors++;
            $display("FAIL %s: codes=%h lt=%b bl=%b zs=%b actual=%h expected=%h",
                     req, c, l, b, z, {zs_out, segs}, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        codes = 16'h1234; lt = 1'b1; zs = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs cleared during reset
        checks++;
        if (segs !== '0 || zs_out !== 1'b0) begin
            errors++;
            $display("FAIL R9 reset: actual=%h expected=0", {zs_out, segs});
        end
        rst_n = 1'b1;

        // R1, R8: each decimal code on every digit, no suppression
        for (int v = 0; v < 10; v++)
            apply_check({4{v[3:0]}}, 1'b0, 1'b0, 1'b0, "R1 R8 glyph");
        // R2: codes 10..15 dark
        for (int v = 10; v < 16; v++)
            apply_check({4{v[3:0]}}, 1'b0, 1'b0, 1'b0, "R2 invalid code");
        // R5 R6: leading zeros blank, zeros after a nonzero digit stay
        apply_check(16'h0050, 1'b0, 1'b0, 1'b1, "R5 R6 leading zeros");
        apply_check(16'h0900, 1'b0, 1'b0, 1'b1, "R6 chain stops");
        apply_check(16'h0050, 1'b0, 1'b0, 1'b0, "R6 chain off");
        // R7: whole group zero with suppression
        apply_check(16'h0000, 1'b0, 1'b0, 1'b1, "R7 all suppressed");
        apply_check(16'h0001, 1'b0, 1'b0, 1'b1, "R7 units nonzero");
        // R4: lamp test over suppressed row, R7 chain dropped
        apply_check(16'h0000, 1'b1, 1'b0, 1'b1, "R4 lamp test");
        apply_check(16'hABCD, 1'b1, 1'b0, 1'b0, "R4 lamp test invalid codes");
        // R3: blanking over lamp test; R7 chain unaffected by blanking
        apply_check(16'h8888, 1'b1, 1'b1, 1'b0, "R3 blank over lamp");
        apply_check(16'h0000, 1'b0, 1'b1, 1'b1, "R3 R7 blank keeps chain");

        // Random patterns, zero-heavy to exercise long chains
        for (int i = 0; i < 400; i++) begin
            logic [4*ND-1:0] c;
            for (int k = 0; k < ND; k++)
                c[4*k +: 4] = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'd0;
            apply_check(c, ($urandom % 6) == 0, ($urandom % 8) == 0,
                        ($urandom % 4) != 0, "R1-random R5 R6 R7");
        end

        // R9: reset mid-run clears, then recovers
        @(negedge clk);
        rst_n = 1'b0; codes = 16'h7777;
        @(negedge clk);
        checks++;
        if (segs !== '0 || zs_out !== 1'b0) begin
            errors++;
            $display("FAIL R9 mid reset: actual=%h expected=0", {zs_out, segs});
        end
        rst_n = 1'b1;
        apply_check(16'h7777, 1'b0, 1'b0, 1'b0, "R9 after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule